// File: doc/BRIEF.md
# Expansion Slot Interrupt Router

This block collects the interrupt pins of a row of expansion slots, a two-pin graphics slot and an on-board USB controller. It merges them onto five shared request lines and then steers each line onto one of sixteen legacy interrupt outputs. Slot pins are wired to the four rotating lines with a per-slot offset. As a result, the first pin of each card tends to land on a different line, and paired slots share one offset. The USB controller has a fifth line of its own. All requests are level sensitive and active low, so any number of cards can drive the same line and the line stays asserted while any of them holds its request.

Software sets up the routing through two plain write ports. One port writes a per-line steering entry: a disable flag plus a 4-bit IRQ number. The other port writes a 16-bit mask of IRQs that are kept for legacy devices. A reserved IRQ is never driven by this block. A steering write that names a reserved IRQ leaves that entry disabled. If the mask is changed later, any reserved output is also blanked. All inputs are levels or single-cycle strobes, so there is no flow control.

Top module: `pirq_router`

## Requirements
- R1: Expansion slot k (k = 1..5) drives `slot_int_n[(k-1)*4 + p]` for pin p (0 = A, 1 = B, 2 = C, 3 = D). Pin p of slot k feeds rotating line (p + r) mod 4, where r is 0 for slots 1, 1 for slot 2, 2 for slot 3, and 3 for slots 4 and 5.
- R2: The graphics slot has two pins on `gfx_int_n[1:0]` (A, B). They use the same offset as slot 1, so pin A feeds line 0 and pin B feeds line 1.
- R3: A line is asserted while at least one of its contributing pins is low. Several pins on one line, or several lines steered to one IRQ, combine by OR. With no line asserted, every IRQ output is low.
- R4: `usb_int_n` low asserts line 4, which no slot pin drives.
- R5: A write with `steer_we` high and `steer_sel` in 0..4 loads that line's entry from `steer_wdata`, where bit 4 is the disable flag and bits 3:0 are the IRQ number. An enabled, asserted line drives `irq_o[n]`. Writes with `steer_sel` 5..7 are ignored.
- R6: An entry with bit 4 set contributes to no output.
- R7: A steering write that enables an IRQ currently marked reserved is not accepted, and the entry becomes disabled.
- R8: `irq_o[n]` is never high while bit n of the reserved mask (written with `rsv_we` / `rsv_wdata`) was set in the previous cycle, including after the mask changes under an already-enabled entry.
- R9: `irq_o` is registered. A change on a pin appears on the output after exactly one rising clock edge.
- R10: After reset all entries are disabled, `irq_o` is zero, and the reserved mask is 16'h2107 (IRQs 0, 1, 2, 8 and 13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gfx_int_n | input | 2 | Graphics slot pins A, B, active low |
| slot_int_n | input | 20 | Expansion slot pins, four per slot, active low |
| usb_int_n | input | 1 | On-board USB interrupt, active low |
| steer_we | input | 1 | Steering entry write strobe |
| steer_sel | input | 3 | Line index of the entry to write |
| steer_wdata | input | 5 | {disable, irq[3:0]} |
| rsv_we | input | 1 | Reserved mask write strobe |
| rsv_wdata | input | 16 | New reserved mask |
| irq_o | output | 16 | Registered legacy IRQ outputs |

## Verification
A pin or USB level reaches `irq_o` one rising edge after it is driven. A steering or mask write takes effect in its register at the edge that samples the strobe, and shows on `irq_o` one edge after that. The bench drives inputs just after a falling edge and samples one falling edge later, so each result is read a half period after the edge that produced it. For R9, the bench also samples the output directly after driving a pin, before any edge, and expects the old value. For mask and steering writes, the write task consumes the register edge, and the bench waits one more edge before it compares.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int ROT_LINES = 4;
  localparam int SLOT_PINS = 4;
  localparam int GFX_PINS  = 2;

  // line offset applied to the pins of expansion slot number slot_num
  function automatic int slot_rotation(input int slot_num);
    if (slot_num <= 1) return 0;
    else if (slot_num >= 4) return 3;
    else return slot_num - 1;
  endfunction
endpackage

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
  parameter int ROT  = 0,
  parameter int PINS = 4
) (
  input  logic [PINS-1:0]                        pin_n,
  output logic [pirq_router_pkg::ROT_LINES-1:0]  line_req
);
  localparam int LINES = pirq_router_pkg::ROT_LINES;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    localparam int SRC = (l - ROT + LINES) % LINES;
    if (SRC < PINS) begin : g_used
      assign line_req[l] = ~pin_n[SRC];
    end else begin : g_none
      assign line_req[l] = 1'b0;
    end
  end
endmodule

// File: rtl/pirq_share.sv
module pirq_share #(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC*pirq_router_pkg::ROT_LINES-1:0] src_req,
  output logic [pirq_router_pkg::ROT_LINES-1:0]         line_lvl
);
  localparam int LINES = pirq_router_pkg::ROT_LINES;

  always_comb begin
    line_lvl = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      line_lvl = line_lvl | src_req[s*LINES +: LINES];
    end
  end
endmodule

// File: rtl/pirq_steer_regs.sv
module pirq_steer_regs #(
  parameter int NUM_PIRQ = 5,
  parameter int NUM_IRQ  = 16,
  parameter int IRQ_W    = 4,
  parameter int SEL_W    = 3,
  parameter logic [NUM_IRQ-1:0] RSV_INIT = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      steer_we,
  input  logic [SEL_W-1:0]          steer_sel,
  input  logic [IRQ_W:0]            steer_wdata,
  input  logic                      rsv_we,
  input  logic [NUM_IRQ-1:0]        rsv_wdata,
  output logic [NUM_PIRQ-1:0]       off_q,
  output logic [NUM_PIRQ*IRQ_W-1:0] tgt_flat,
  output logic [NUM_IRQ-1:0]        rsv_q
);
  logic [IRQ_W-1:0] tgt_q [NUM_PIRQ];
  logic [IRQ_W-1:0] wr_irq;
  logic             wr_off;
  logic             sel_ok;

  assign wr_irq = steer_wdata[IRQ_W-1:0];
  assign wr_off = steer_wdata[IRQ_W];
  assign sel_ok = steer_sel < SEL_W'(NUM_PIRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '1;
      rsv_q <= RSV_INIT;
      for (int j = 0; j < NUM_PIRQ; j++) tgt_q[j] <= '0;
    end else begin
      if (rsv_we) rsv_q <= rsv_wdata;
      if (steer_we && sel_ok) begin
        if (wr_off) begin
          off_q[steer_sel] <= 1'b1;
          tgt_q[steer_sel] <= wr_irq;
        end else if (rsv_q[wr_irq]) begin
          off_q[steer_sel] <= 1'b1;
        end else begin
          off_q[steer_sel] <= 1'b0;
          tgt_q[steer_sel] <= wr_irq;
        end
      end
    end
  end

  for (genvar j = 0; j < NUM_PIRQ; j++) begin : g_flat
    assign tgt_flat[j*IRQ_W +: IRQ_W] = tgt_q[j];
  end
endmodule

// File: rtl/pirq_irq_fanout.sv
module pirq_irq_fanout #(
  parameter int NUM_PIRQ = 5,
  parameter int NUM_IRQ  = 16,
  parameter int IRQ_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PIRQ-1:0]       pirq_lvl,
  input  logic [NUM_PIRQ-1:0]       off_q,
  input  logic [NUM_PIRQ*IRQ_W-1:0] tgt_flat,
  input  logic [NUM_IRQ-1:0]        rsv_q,
  output logic [NUM_IRQ-1:0]        irq_o
);
  logic [NUM_IRQ-1:0] irq_d;

  always_comb begin
    irq_d = '0;
    for (int j = 0; j < NUM_PIRQ; j++) begin
      if (pirq_lvl[j] && !off_q[j]) irq_d[tgt_flat[j*IRQ_W +: IRQ_W]] = 1'b1;
    end
    irq_d = irq_d & ~rsv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NUM_SLOTS = 5,
  parameter int NUM_IRQ   = 16,
  parameter logic [NUM_IRQ-1:0] RSV_INIT = 16'h2107
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [pirq_router_pkg::GFX_PINS-1:0]          gfx_int_n,
  input  logic [NUM_SLOTS*pirq_router_pkg::SLOT_PINS-1:0] slot_int_n,
  input  logic                                          usb_int_n,
  input  logic                                          steer_we,
  input  logic [$clog2(pirq_router_pkg::ROT_LINES+1)-1:0] steer_sel,
  input  logic [$clog2(NUM_IRQ):0]                      steer_wdata,
  input  logic                                          rsv_we,
  input  logic [NUM_IRQ-1:0]                            rsv_wdata,
  output logic [NUM_IRQ-1:0]                            irq_o
);
  import pirq_router_pkg::*;

  localparam int NUM_PIRQ = ROT_LINES + 1;
  localparam int IRQ_W    = $clog2(NUM_IRQ);
  localparam int SEL_W    = $clog2(NUM_PIRQ);
  localparam int NUM_SRC  = NUM_SLOTS + 1;

  logic [NUM_SRC*ROT_LINES-1:0] src_req;
  logic [ROT_LINES-1:0]         shared_lvl;
  logic [NUM_PIRQ-1:0]          pirq_lines;
  logic [NUM_PIRQ-1:0]          steer_off;
  logic [NUM_PIRQ*IRQ_W-1:0]    steer_tgt;
  logic [NUM_IRQ-1:0]           rsv_mask;

  pirq_slot_map #(.ROT(slot_rotation(1)), .PINS(GFX_PINS)) gfx_map_i (
    .pin_n    (gfx_int_n),
    .line_req (src_req[ROT_LINES-1:0])
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    pirq_slot_map #(.ROT(slot_rotation(s + 1)), .PINS(SLOT_PINS)) map_i (
      .pin_n    (slot_int_n[s*SLOT_PINS +: SLOT_PINS]),
      .line_req (src_req[(s+1)*ROT_LINES +: ROT_LINES])
    );
  end

  pirq_share #(.NUM_SRC(NUM_SRC)) share_i (
    .src_req  (src_req),
    .line_lvl (shared_lvl)
  );

  assign pirq_lines = {~usb_int_n, shared_lvl};

  pirq_steer_regs #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W), .SEL_W(SEL_W), .RSV_INIT(RSV_INIT)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .steer_we    (steer_we),
    .steer_sel   (steer_sel),
    .steer_wdata (steer_wdata),
    .rsv_we      (rsv_we),
    .rsv_wdata   (rsv_wdata),
    .off_q       (steer_off),
    .tgt_flat    (steer_tgt),
    .rsv_q       (rsv_mask)
  );

  pirq_irq_fanout #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) fanout_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pirq_lvl (pirq_lines),
    .off_q    (steer_off),
    .tgt_flat (steer_tgt),
    .rsv_q    (rsv_mask),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_PIRQ = 5,
  parameter int NUM_IRQ  = 16,
  parameter int SEL_W    = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_PIRQ-1:0]       pirq_lines,
  input logic [NUM_PIRQ-1:0]       steer_off,
  input logic [NUM_IRQ-1:0]        rsv_mask,
  input logic                      steer_we,
  input logic [SEL_W-1:0]          steer_sel,
  input logic [$clog2(NUM_IRQ):0]  steer_wdata,
  input logic [NUM_IRQ-1:0]        irq_o
);
  localparam int IRQ_W = $clog2(NUM_IRQ);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lines == '0) |=> (irq_o == '0));

  assert_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&steer_off) |=> (irq_o == '0));

  assert_rsv_write_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_we && (steer_sel < SEL_W'(NUM_PIRQ)) && !steer_wdata[IRQ_W]
      && rsv_mask[steer_wdata[IRQ_W-1:0]])
    |=> steer_off[$past(steer_sel)]);

  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_o & $past(rsv_mask)) == '0));

  assert_reset_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0));
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pirq_lines  (pirq_lines),
  .steer_off   (steer_off),
  .rsv_mask    (rsv_mask),
  .steer_we    (steer_we),
  .steer_sel   (steer_sel),
  .steer_wdata (steer_wdata),
  .irq_o       (irq_o)
);

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 5;
  localparam int NIRQ  = 16;
  localparam int NLINE = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        gfx_n = '1;
  logic [NSLOT*4-1:0] slot_n = '1;
  logic              usb_n = 1'b1;
  logic              steer_we = 1'b0;
  logic [2:0]        steer_sel = '0;
  logic [4:0]        steer_wdata = '0;
  logic              rsv_we = 1'b0;
  logic [NIRQ-1:0]   rsv_wdata = '0;
  logic [NIRQ-1:0]   irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_router dut_i (
    .clk(clk), .rst_n(rst_n), .gfx_int_n(gfx_n), .slot_int_n(slot_n), .usb_int_n(usb_n),
    .steer_we(steer_we), .steer_sel(steer_sel), .steer_wdata(steer_wdata),
    .rsv_we(rsv_we), .rsv_wdata(rsv_wdata), .irq_o(irq_o)
  );

  function automatic int exp_rot(input int k);
    case (k)
      1: return 0;
      2: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [NIRQ-1:0] exp);
    n_vec++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%h expected %h", tag, irq_o, exp);
    end
  endtask

  task automatic steer(input int j, input logic [4:0] v);
    steer_we = 1'b1; steer_sel = 3'(j); steer_wdata = v;
    step();
    steer_we = 1'b0;
  endtask

  task automatic reserve(input logic [NIRQ-1:0] m);
    rsv_we = 1'b1; rsv_wdata = m;
    step();
    rsv_we = 1'b0;
  endtask

  // line j < 4 via slot 1 pin j (offset 0), line 4 via USB
  task automatic drive_line(input int j, input bit on);
    if (j == 4) usb_n = ~on;
    else slot_n[j] = ~on;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    check("R10 in reset", '0);
    rst_n = 1'b1;
    step();
    check("R10 after reset", '0);

    // R10: default mask reserves IRQ0; IRQ3 free
    steer(0, 5'd0);
    drive_line(0, 1);
    step();
    check("R10 default mask IRQ0", '0);
    steer(0, 5'd3);
    step();
    check("R10 default mask IRQ3", 16'h0008);
    drive_line(0, 0);
    reserve('0);
    step();

    // R5: full sweep of line x IRQ
    for (int j = 0; j < NLINE; j++) begin
      for (int i = 0; i < NIRQ; i++) begin
        steer(j, 5'(i));
        drive_line(j, 1);
        step();
        check("R5 steer sweep", NIRQ'(1) << i);
        drive_line(j, 0);
        step();
        check("R9 release", '0);
      end
    end

    for (int j = 0; j < NLINE; j++) steer(j, 5'(j + 4));
    steer(7, 5'd0); // R5: out-of-range index ignored
    drive_line(0, 1);
    step();
    check("R5 sel 7 ignored", 16'h0010);
    drive_line(0, 0);
    step();

    // R1: every pin of every expansion slot
    for (int k = 1; k <= NSLOT; k++) begin
      for (int p = 0; p < 4; p++) begin
        slot_n[(k-1)*4 + p] = 1'b0;
        step();
        check("R1 slot rotation", NIRQ'(1) << (((p + exp_rot(k)) % 4) + 4));
        slot_n = '1;
        step();
      end
    end

    // R2: graphics slot pins A, B
    for (int p = 0; p < 2; p++) begin
      gfx_n[p] = 1'b0;
      step();
      check("R2 graphics pin", NIRQ'(1) << (p + 4));
      gfx_n = '1;
      step();
    end

    // R4: USB line
    usb_n = 1'b0;
    step();
    check("R4 usb line", 16'h0100);
    usb_n = 1'b1;
    step();

    // R3: shared line from slot 1 pin A and slot 2 pin D
    slot_n[0] = 1'b0; slot_n[7] = 1'b0;
    step();
    check("R3 two sources", 16'h0010);
    slot_n[0] = 1'b1;
    step();
    check("R3 one source left", 16'h0010);
    slot_n[7] = 1'b1;
    step();
    check("R3 all released", '0);
    steer(1, 5'd4);
    drive_line(0, 1); drive_line(1, 1);
    step();
    check("R3 two lines one IRQ", 16'h0010);
    drive_line(0, 0);
    step();
    check("R3 one line left", 16'h0010);
    drive_line(1, 0);
    step();

    // R9: no change before the edge, change after one edge
    drive_line(2, 1);
    check("R9 before edge", '0);
    step();
    check("R9 after one edge", 16'h0040);
    drive_line(2, 0);
    step();

    // R6: disable flag
    steer(0, 5'h14);
    drive_line(0, 1);
    step();
    check("R6 disabled entry", '0);
    drive_line(0, 0);

    // R7: write naming reserved IRQ 9 leaves line 1 disabled
    reserve(16'h0200);
    steer(1, 5'd9);
    drive_line(1, 1);
    step();
    check("R7 reserved write", '0);
    drive_line(1, 0);

    // R8: mask raised under an enabled entry
    reserve('0);
    steer(2, 5'd6);
    drive_line(2, 1);
    step();
    check("R8 before mask", 16'h0040);
    reserve(16'h0040);
    check("R8 mask edge", 16'h0040);
    step();
    check("R8 masked", '0);
    reserve('0);
    step();
    check("R8 unmasked", 16'h0040);
    drive_line(2, 0);
    step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule